// File: doc/BRIEF.md
# Multi-domain reset pulse generator

This block drives one active-low reset output for each of a parameterized number of reset domains, all on a single clock. Each domain has its own hold length in clock cycles. A domain enters reset when its hardware trigger input is high and its enable bit is set, or when its software request bit is high. The enable bit gates the hardware trigger only. The block holds that domain in reset until the hold length has elapsed after the last cycle in which a trigger was sampled.

Every domain output is ANDed with the synchronous active-low main reset, so the main reset always forces all domains into reset. The software request and enable vectors come from register storage outside the block. The bus interface is also outside it.

Hold lengths are packed into one parameter vector of `CNT_W`-bit fields. Domain d uses bits `[d*CNT_W +: CNT_W]`, and every field must be at least 1.

Top module: `rst_pulse_gen`

## Requirements
- R1: While `rst_ni` is low, every bit of `dom_rst_no` is 0. After a clock edge with `rst_ni` low, all hold counters are clear, so once `rst_ni` returns high with no trigger pending, every output reads 1.
- R2: A trigger for domain d that is sampled at a rising edge drives `dom_rst_no[d]` low from that edge on.
- R3: After the last edge at which a trigger for domain d was sampled, `dom_rst_no[d]` stays low for exactly `HOLD(d)` further rising edges. It reads 1 after the `HOLD(d)`-th edge.
- R4: A trigger held high over several edges reloads the count at each of those edges. Release is measured from the last of them.
- R5: When `hw_en_i[d]` is 0, `hw_trig_i[d]` has no effect on `dom_rst_no[d]`.
- R6: `sw_req_i[d]` triggers domain d whatever the value of `hw_en_i[d]`.
- R7: A trigger on one domain neither changes the output of any other domain nor shifts the release time of any other domain.
- R8: Asserting `rst_ni` in the middle of a hold clears that hold. Once `rst_ni` is high again, the domain reads 1 with no remaining hold time.
- R9: A domain whose hold length is 1 is held low for exactly one cycle after a single-edge trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low main reset; overrides all outputs |
| hw_trig_i | input | N_DOM | Per-domain hardware trigger, active high |
| hw_en_i | input | N_DOM | Per-domain enable for hardware triggers |
| sw_req_i | input | N_DOM | Per-domain software request, active high, not masked |
| dom_rst_no | output | N_DOM | Per-domain reset output, active low |

## Verification
The bench measures the exact release edge for every domain, including the length-1 domain. An off-by-one counter would show up there as a pulse one cycle short or one cycle long. It holds a trigger over several edges, which catches a counter that ignores reloads and releases early. It drives a masked hardware trigger and an unmasked software request, which catches a mask applied to the wrong source. It overlaps holds on two domains, which catches shared or cross-wired counters. It pulses the main reset during a hold, which catches a design that leaves residual hold time or fails to force the outputs low.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
  localparam int unsigned RSTGEN_MAX_CNT_W = 16;

  function automatic logic [RSTGEN_MAX_CNT_W-1:0] hold_field(
      input logic [RSTGEN_MAX_CNT_W*32-1:0] vec, input int unsigned idx,
      input int unsigned w);
    logic [RSTGEN_MAX_CNT_W-1:0] r;
    r = '0;
    for (int unsigned b = 0; b < w; b++) r[b] = vec[idx*w+b];
    return r;
  endfunction
endpackage

// File: rtl/rstgen_trig_merge.sv
module rstgen_trig_merge #(
  parameter int unsigned N_DOM = 4
) (
  input  logic [N_DOM-1:0] hw_trig_i,
  input  logic [N_DOM-1:0] hw_en_i,
  input  logic [N_DOM-1:0] sw_req_i,
  output logic [N_DOM-1:0] fire_o
);
  // mask applies to hardware source only
  always_comb fire_o = (hw_trig_i & hw_en_i) | sw_req_i;
endmodule

// File: rtl/rstgen_hold_cnt.sv
module rstgen_hold_cnt #(
  parameter int unsigned      CNT_W = 8,
  parameter logic [CNT_W-1:0] HOLD  = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic active_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (fire_i)          cnt_q <= HOLD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  assert_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> (cnt_q == HOLD));

  assert_countdown_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fire_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fire_i && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/rstgen_out_gate.sv
module rstgen_out_gate #(
  parameter int unsigned N_DOM = 4
) (
  input  logic             rst_ni,
  input  logic [N_DOM-1:0] active_i,
  output logic [N_DOM-1:0] rst_no
);
  // main reset overrides every domain
  always_comb rst_no = {N_DOM{rst_ni}} & ~active_i;
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen #(
  parameter int unsigned             N_DOM    = 4,
  parameter int unsigned             CNT_W    = 8,
  parameter logic [N_DOM*CNT_W-1:0]  HOLD_LEN = {8'd5, 8'd3, 8'd2, 8'd1}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_DOM-1:0] hw_trig_i,
  input  logic [N_DOM-1:0] hw_en_i,
  input  logic [N_DOM-1:0] sw_req_i,
  output logic [N_DOM-1:0] dom_rst_no
);
  localparam int unsigned LAST_DOM = N_DOM - 1;

  if (N_DOM < 1) begin : g_bad_ndom
    $error("rst_pulse_gen: N_DOM must be at least 1");
  end
  if (CNT_W > rstgen_pkg::RSTGEN_MAX_CNT_W || CNT_W < 1) begin : g_bad_w
    $error("rst_pulse_gen: CNT_W out of range");
  end

  logic [N_DOM-1:0] fire;
  logic [N_DOM-1:0] active;

  rstgen_trig_merge #(.N_DOM(N_DOM)) u_merge (
    .hw_trig_i (hw_trig_i),
    .hw_en_i   (hw_en_i),
    .sw_req_i  (sw_req_i),
    .fire_o    (fire)
  );

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    localparam logic [CNT_W-1:0] HOLD_D = HOLD_LEN[d*CNT_W +: CNT_W];
    if (HOLD_D == '0) begin : g_bad_hold
      $error("rst_pulse_gen: hold length must be at least 1");
    end

    rstgen_hold_cnt #(.CNT_W(CNT_W), .HOLD(HOLD_D)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .fire_i   (fire[d]),
      .active_o (active[d])
    );

    assert_trig_asserts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sw_req_i[d] || (hw_trig_i[d] && hw_en_i[d])) |=> !dom_rst_no[d]);

    assert_sw_unmasked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sw_req_i[d] && !hw_en_i[d]) |=> !dom_rst_no[d]);

    assert_mask_blocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dom_rst_no[d] && !sw_req_i[d] && !hw_en_i[d]) |=> dom_rst_no[d]);
  end

  rstgen_out_gate #(.N_DOM(N_DOM)) u_gate (
    .rst_ni   (rst_ni),
    .active_i (active),
    .rst_no   (dom_rst_no)
  );

  assert_main_clears_R8: assert property (@(posedge clk_i)
    !rst_ni |=> (active == '0));

  assert_main_forces_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (dom_rst_no == '0));

  assert_last_dom_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fire[LAST_DOM] && dom_rst_no[LAST_DOM]) |=> dom_rst_no[LAST_DOM]);
endmodule

// File: tb/rst_pulse_gen_tb.sv
module rst_pulse_gen_tb;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned N_DOM = 4;
  localparam int unsigned CNT_W = 8;
  localparam logic [N_DOM*CNT_W-1:0] HOLD_LEN = {8'd5, 8'd3, 8'd2, 8'd1};
  localparam int unsigned WDOG = 20000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N_DOM-1:0] hw_trig = '0, hw_en = '1, sw_req = '0;
  logic [N_DOM-1:0] dom_rst_n;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_pulse_gen #(.N_DOM(N_DOM), .CNT_W(CNT_W), .HOLD_LEN(HOLD_LEN)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .hw_trig_i(hw_trig), .hw_en_i(hw_en),
    .sw_req_i(sw_req), .dom_rst_no(dom_rst_n)
  );

  function automatic int hold(input int d);
    return int'(HOLD_LEN[d*CNT_W +: CNT_W]);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // count edges from now until domain d releases
  task automatic edges_to_release(input int d, output int n);
    n = 0;
    while (dom_rst_n[d] == 1'b0 && n < 100) begin step(); n++; end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; step(); step();
    chk(dom_rst_n == '0, "R1 outputs low in reset", int'(dom_rst_n), 0);
    rst_ni = 1'b1; #1;
    chk(dom_rst_n == '1, "R1 outputs high after reset", int'(dom_rst_n), 15);
  endtask

  task automatic t_hw_each();
    for (int d = 0; d < N_DOM; d++) begin
      int n;
      hw_en = '1; hw_trig[d] = 1'b1; step(); hw_trig = '0;
      chk(dom_rst_n[d] == 1'b0, "R2 hw trigger asserts", int'(dom_rst_n[d]), 0);
      edges_to_release(d, n);
      chk(n == hold(d), "R3 hold length hw", n, hold(d));
      step();
    end
  endtask

  task automatic t_sw_masked();
    for (int d = 0; d < N_DOM; d++) begin
      int n;
      hw_en = '0; sw_req[d] = 1'b1; step(); sw_req = '0;
      chk(dom_rst_n[d] == 1'b0, "R6 sw trigger ignores mask", int'(dom_rst_n[d]), 0);
      edges_to_release(d, n);
      chk(n == hold(d), "R6 sw hold length", n, hold(d));
    end
    hw_en = '1; step();
  endtask

  task automatic t_hw_masked();
    bit seen_low = 0;
    hw_en = 4'b0101; hw_trig = 4'b1010;
    for (int k = 0; k < 4; k++) begin
      step();
      if (dom_rst_n != '1) seen_low = 1;
    end
    hw_trig = '0; hw_en = '1;
    chk(!seen_low, "R5 masked hw trigger ignored", int'(seen_low), 0);
  endtask

  task automatic t_held();
    int n;
    bit early = 0;
    hw_trig[3] = 1'b1;
    for (int k = 0; k < 8; k++) begin
      step();
      if (dom_rst_n[3]) early = 1;
    end
    hw_trig = '0;
    chk(!early, "R4 held trigger keeps reset", int'(early), 0);
    edges_to_release(3, n);
    chk(n == hold(3), "R4 release after last trigger", n, hold(3));
  endtask

  task automatic t_indep();
    int n;
    bit other = 0;
    hw_trig[3] = 1'b1; step(); hw_trig = '0;
    step(); n = 1;
    hw_trig[1] = 1'b1; step(); n++; hw_trig = '0;
    if (dom_rst_n[0] == 1'b0 || dom_rst_n[2] == 1'b0) other = 1;
    while (dom_rst_n[3] == 1'b0 && n < 100) begin
      step(); n++;
      if (dom_rst_n[0] == 1'b0 || dom_rst_n[2] == 1'b0) other = 1;
    end
    chk(n == hold(3), "R7 release time unaffected", n, hold(3));
    chk(!other, "R7 untouched domains stay high", int'(other), 0);
    chk(dom_rst_n[1] == 1'b1, "R7 domain 1 released", int'(dom_rst_n[1]), 1);
  endtask

  task automatic t_main_override();
    hw_trig[3] = 1'b1; step(); hw_trig = '0; step();
    rst_ni = 1'b0; #1;
    chk(dom_rst_n == '0, "R1 main reset forces low", int'(dom_rst_n), 0);
    step();
    rst_ni = 1'b1; #1;
    chk(dom_rst_n[3] == 1'b1, "R8 hold cleared by main reset", int'(dom_rst_n[3]), 1);
    step();
    chk(dom_rst_n == '1, "R8 stays released", int'(dom_rst_n), 15);
  endtask

  task automatic t_single();
    hw_trig[0] = 1'b1; step(); hw_trig = '0;
    chk(dom_rst_n[0] == 1'b0, "R9 one cycle low", int'(dom_rst_n[0]), 0);
    step();
    chk(dom_rst_n[0] == 1'b1, "R9 released after one cycle", int'(dom_rst_n[0]), 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < WDOG; c++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", WDOG, 0);
    finish_run();
  end

  initial begin
    #1;
    t_reset();
    t_hw_each();
    t_sw_masked();
    t_hw_masked();
    t_held();
    t_indep();
    t_main_override();
    t_single();
    finish_run();
  end
endmodule